// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Selectable Rounding

This block is the arithmetic core of a fixed-point signal-processing datapath. Each clock it accepts two signed 24-bit fractions in Q1.23 format and multiplies them at full width. The 48-bit product is shifted left by one to drop its redundant sign bit. The block then clears the accumulator, loads it with the product, or adds the product to it or subtracts it from it. The accumulator is 56 bits wide, so 8 guard bits above the 48-bit product range absorb intermediate growth. The accumulator wraps modulo 2^56.

When a store is requested, the block converts the accumulator value visible in that cycle to a 24-bit word. It takes the 32-bit upper part (bits 55..24) and rounds it with the 24 discarded low bits under one of three modes: truncation, round-to-nearest, or convergent round-half-to-even. If saturation is enabled, it then clamps the rounded value into the signed 24-bit range and raises an overflow flag. The result is presented one cycle later. A two-state presentation machine drives the valid output. Its states are ST_IDLE and ST_PRESENT. Any cycle with `store_req` high moves it to ST_PRESENT, and any cycle with `store_req` low moves it to ST_IDLE; both transitions can start from either state. The operation decoder uses named codes OP_CLEAR, OP_LOAD, OP_MAC and OP_MSU, and the rounding select uses RND_TRUNC, RND_NEAREST and RND_CONV, with code 3 (RND_RSVD) behaving as truncation.

Top module: `fxp_mac_round`

## Requirements
- R1: While reset is asserted and after it is released, `acc_out` is 0, `store_valid` is 0, `store_ovf` is 0 and `store_data` is 0.
- R2: With `op_en`=1 and `op_sel`=00 (clear), `acc_out` is 0 after the next rising edge.
- R3: With `op_en`=1 and `op_sel`=01 (load), after the next edge `acc_out` equals 2*x*y, with x and y the signed operands, sign-extended to 56 bits. For x=y=-1.0 this gives +2^47.
- R4: With `op_en`=1, `op_sel`=10 (MAC) adds 2*x*y to the accumulator and `op_sel`=11 (MSU) subtracts it, one operation per cycle, modulo 2^56.
- R5: With `op_en`=0 the accumulator keeps its value whatever `op_sel`, `x_in` and `y_in` are.
- R6: `store_req` high in a cycle samples the accumulator value visible in that cycle, before that edge's operation. The converted word appears with `store_valid`=1 after that edge. `store_valid` is 0 in the cycle after any cycle without a request.
- R7: With `rnd_sel`=00, or the reserved code 11, the rounded value is acc[55:24] taken as a signed value, and the low 24 bits are dropped.
- R8: With `rnd_sel`=01, the rounded value is acc[55:24]+acc[23]. Halves and above go toward +infinity.
- R9: With `rnd_sel`=10, the rounding matches R8 except for an exact half (acc[23:0]=0x800000). In that case the rounded value is incremented only when acc[24] is 1, so its LSB ends at 0.
- R10: With `sat_en`=1, a rounded value above 0x7FFFFF stores 0x7FFFFF and a value below -0x800000 stores 0x800000, both with `store_ovf`=1. An in-range value stores unchanged with `store_ovf`=0.
- R11: With `sat_en`=0, `store_data` is the low 24 bits of the rounded value and `store_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Perform the selected accumulator operation this cycle |
| op_sel | input | 2 | 00 clear, 01 load, 10 MAC, 11 MSU |
| x_in | input | 24 | Signed Q1.23 operand |
| y_in | input | 24 | Signed Q1.23 operand |
| store_req | input | 1 | Convert the current accumulator value |
| rnd_sel | input | 2 | 00 truncate, 01 nearest, 10 convergent, 11 truncate |
| sat_en | input | 1 | Clamp out-of-range results |
| acc_out | output | 56 | Accumulator value |
| store_valid | output | 1 | `store_data` holds a fresh result |
| store_data | output | 24 | Rounded and optionally saturated result |
| store_ovf | output | 1 | The result was clamped |

## Verification
An operation presented in one cycle shows on `acc_out` after the next rising edge. A store request shows on `store_valid`, `store_data` and `store_ovf` after that same edge. The store converts the pre-edge accumulator, so a store and a MAC issued in the same cycle see different accumulator values. The bench drives every input at a falling edge and compares all outputs at the following falling edge. It steps a reference model that computes the store result from the old model accumulator before applying the new operation. Directed exact-half, below-half and above-half tie cases, along with 56-bit guard-range growth, sit beside a seeded random run.

// File: rtl/fxp_mac_pkg.sv
`timescale 1ns/1ps
package fxp_mac_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR = 2'b00,
        OP_LOAD  = 2'b01,
        OP_MAC   = 2'b10,
        OP_MSU   = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        RND_TRUNC   = 2'b00,
        RND_NEAREST = 2'b01,
        RND_CONV    = 2'b10,
        RND_RSVD    = 2'b11
    } rnd_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } store_state_e;
endpackage

// File: rtl/fxp_mult.sv
`timescale 1ns/1ps
// Full-width signed product, realigned for Q1.23 x Q1.23 and sign-extended.
module fxp_mult #(
    parameter int OPW  = 24,
    parameter int ACCW = 56
) (
    input  logic signed [OPW-1:0]  x_op,
    input  logic signed [OPW-1:0]  y_op,
    output logic signed [ACCW-1:0] prod_aligned
);
    localparam int PW  = 2 * OPW;
    localparam int EXT = ACCW - PW - 1;

    logic signed [PW-1:0] prod_full;

    always_comb begin
        prod_full    = PW'(x_op) * PW'(y_op);
        prod_aligned = {{EXT{prod_full[PW-1]}}, prod_full, 1'b0};
    end
endmodule

// File: rtl/fxp_accum.sv
`timescale 1ns/1ps
// Guard-bit accumulator register with the four named operations.
module fxp_accum
    import fxp_mac_pkg::*;
#(
    parameter int ACCW = 56
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_en,
    input  mac_op_e                op,
    input  logic signed [ACCW-1:0] prod,
    output logic signed [ACCW-1:0] acc_q
);
    logic signed [ACCW-1:0] acc_d;

    always_comb begin
        acc_d = acc_q;
        if (op_en) begin
            unique case (op)
                OP_CLEAR: acc_d = '0;
                OP_LOAD:  acc_d = prod;
                OP_MAC:   acc_d = acc_q + prod;
                OP_MSU:   acc_d = acc_q - prod;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/fxp_round_sat.sv
`timescale 1ns/1ps
// Rounds the accumulator to the result field and optionally clamps it.
module fxp_round_sat
    import fxp_mac_pkg::*;
#(
    parameter int OPW  = 24,
    parameter int ACCW = 56
) (
    input  logic [ACCW-1:0] acc,
    input  rnd_mode_e       mode,
    input  logic            sat_en,
    output logic [OPW-1:0]  result,
    output logic            ovf
);
    localparam int KEEPW = ACCW - OPW;
    localparam int EXTW  = KEEPW + 1;

    logic [EXTW-1:0] keep_ext;
    logic [EXTW-1:0] rounded;
    logic            low_msb;
    logic            low_rest;
    logic            bump;
    logic            in_range;

    always_comb begin
        keep_ext = {acc[ACCW-1], acc[ACCW-1:OPW]};
        low_msb  = acc[OPW-1];
        low_rest = |acc[OPW-2:0];
        unique case (mode)
            RND_NEAREST: bump = low_msb;
            RND_CONV:    bump = low_msb & (low_rest | keep_ext[0]);
            RND_TRUNC,
            RND_RSVD:    bump = 1'b0;
        endcase
        rounded  = keep_ext + EXTW'(bump);
        // in range when all bits from the result sign upward agree
        in_range = (&rounded[EXTW-1:OPW-1]) | ~(|rounded[EXTW-1:OPW-1]);
        if (sat_en && !in_range) begin
            result = rounded[EXTW-1] ? {1'b1, {(OPW-1){1'b0}}}
                                     : {1'b0, {(OPW-1){1'b1}}};
            ovf    = 1'b1;
        end else begin
            result = rounded[OPW-1:0];
            ovf    = 1'b0;
        end
    end
endmodule

// File: rtl/fxp_mac_round.sv
`timescale 1ns/1ps
// Top: multiplier, accumulator, store conversion and result presentation.
module fxp_mac_round
    import fxp_mac_pkg::*;
#(
    parameter int OPW   = 24,
    parameter int GUARD = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_en,
    input  logic [1:0]                op_sel,
    input  logic [OPW-1:0]            x_in,
    input  logic [OPW-1:0]            y_in,
    input  logic                      store_req,
    input  logic [1:0]                rnd_sel,
    input  logic                      sat_en,
    output logic [2*OPW+GUARD-1:0]    acc_out,
    output logic                      store_valid,
    output logic [OPW-1:0]            store_data,
    output logic                      store_ovf
);
    localparam int ACCW = 2 * OPW + GUARD;

    logic signed [ACCW-1:0] prod_aligned;
    logic signed [ACCW-1:0] acc_q;
    logic [OPW-1:0]         conv_word;
    logic                   conv_ovf;
    store_state_e           st_q;
    store_state_e           st_d;

    fxp_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
        .x_op         ($signed(x_in)),
        .y_op         ($signed(y_in)),
        .prod_aligned (prod_aligned)
    );

    fxp_accum #(.ACCW(ACCW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .op_en (op_en),
        .op    (mac_op_e'(op_sel)),
        .prod  (prod_aligned),
        .acc_q (acc_q)
    );

    fxp_round_sat #(.OPW(OPW), .ACCW(ACCW)) u_rs (
        .acc    (acc_q),
        .mode   (rnd_mode_e'(rnd_sel)),
        .sat_en (sat_en),
        .result (conv_word),
        .ovf    (conv_ovf)
    );

    assign acc_out = acc_q;

    // presentation state machine: next-state logic
    always_comb begin
        unique case (st_q)
            ST_IDLE:    st_d = store_req ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: st_d = store_req ? ST_PRESENT : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // output register: captures the word on a request, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_data <= '0;
            store_ovf  <= 1'b0;
        end else if (store_req) begin
            store_data <= conv_word;
            store_ovf  <= conv_ovf;
        end
    end

    assign store_valid = (st_q == ST_PRESENT);
endmodule

// File: rtl/fxp_mac_round_chk.sv
`timescale 1ns/1ps
module fxp_mac_round_chk #(
    parameter int OPW   = 24,
    parameter int GUARD = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   op_en,
    input logic [1:0]             op_sel,
    input logic                   store_req,
    input logic                   sat_en,
    input logic [2*OPW+GUARD-1:0] acc_out,
    input logic                   store_valid,
    input logic [OPW-1:0]         store_data,
    input logic                   store_ovf
);
    localparam logic [OPW-1:0] MAXPOS = {1'b0, {(OPW-1){1'b1}}};
    localparam logic [OPW-1:0] MAXNEG = {1'b1, {(OPW-1){1'b0}}};

    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_sel == 2'b00) |=> (acc_out == '0));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(acc_out));

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> store_valid);

    a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !store_req |=> !store_valid);

    a_r10_ovf_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        store_ovf |-> (store_valid || $stable(store_data)) &&
                      (store_data == MAXPOS || store_data == MAXNEG));

    a_r11_no_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !sat_en) |=> !store_ovf);
endmodule

bind fxp_mac_round fxp_mac_round_chk #(.OPW(OPW), .GUARD(GUARD)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_en       (op_en),
    .op_sel      (op_sel),
    .store_req   (store_req),
    .sat_en      (sat_en),
    .acc_out     (acc_out),
    .store_valid (store_valid),
    .store_data  (store_data),
    .store_ovf   (store_ovf)
);

// File: tb/fxp_mac_round_test.sv
`timescale 1ns/1ps
module fxp_mac_round_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_en = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [23:0] x_in = '0;
    logic [23:0] y_in = '0;
    logic        store_req = 1'b0;
    logic [1:0]  rnd_sel = 2'b00;
    logic        sat_en = 1'b0;
    logic [55:0] acc_out;
    logic        store_valid;
    logic [23:0] store_data;
    logic        store_ovf;

    int n_chk = 0;
    int n_bad = 0;
    longint acc_m = 0;

    always #2.5 clk = ~clk;

    fxp_mac_round uut (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_sel(op_sel),
        .x_in(x_in), .y_in(y_in), .store_req(store_req), .rnd_sel(rnd_sel),
        .sat_en(sat_en), .acc_out(acc_out), .store_valid(store_valid),
        .store_data(store_data), .store_ovf(store_ovf)
    );

    function automatic longint wrap56(longint v);
        return (v <<< 8) >>> 8;
    endfunction

    function automatic longint prod_of(logic [23:0] a, logic [23:0] b);
        longint sa = $signed(a);
        longint sb = $signed(b);
        return 2 * sa * sb;
    endfunction

    function automatic longint round_of(longint a, logic [1:0] m);
        longint keep = a >>> 24;
        longint low  = a & 64'hFF_FFFF;
        case (m)
            2'b01:   return keep + ((low >= 64'h80_0000) ? 1 : 0);
            2'b10:   return keep + (((low > 64'h80_0000) ||
                                     (low == 64'h80_0000 && keep[0])) ? 1 : 0);
            default: return keep;
        endcase
    endfunction

    task automatic chk(string tag, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic cyc(logic en, logic [1:0] op, logic [23:0] x, logic [23:0] y,
                       logic st, logic [1:0] rm, logic sat);
        longint r, ed;
        logic   eo;
        string  tacc, tdat, tovf;
        op_en = en; op_sel = op; x_in = x; y_in = y;
        store_req = st; rnd_sel = rm; sat_en = sat;
        r = round_of(acc_m, rm);
        if (sat && r > 64'sd8388607)       begin ed = 64'h7F_FFFF; eo = 1'b1; end
        else if (sat && r < -64'sd8388608) begin ed = 64'h80_0000; eo = 1'b1; end
        else                               begin ed = r & 64'hFF_FFFF; eo = 1'b0; end
        tdat = (rm == 2'b01) ? "R8 nearest" : (rm == 2'b10) ? "R9 convergent" : "R7 truncate";
        tovf = sat ? "R10 saturate" : "R11 wrap";
        tacc = "R5 hold";
        if (en) begin
            case (op)
                2'b00: begin acc_m = 0; tacc = "R2 clear"; end
                2'b01: begin acc_m = wrap56(prod_of(x, y)); tacc = "R3 load"; end
                2'b10: begin acc_m = wrap56(acc_m + prod_of(x, y)); tacc = "R4 mac"; end
                default: begin acc_m = wrap56(acc_m - prod_of(x, y)); tacc = "R4 msu"; end
            endcase
        end
        @(negedge clk);
        chk(tacc, wrap56(longint'(acc_out)), acc_m);
        chk("R6 valid", longint'(store_valid), longint'(st));
        if (st) begin
            chk(tdat, longint'(store_data), ed);
            chk(tovf, longint'(store_ovf), longint'(eo));
        end
    endtask

    initial begin
        int cyc_cnt = 0;
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 50000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
                report();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 acc", longint'(acc_out), 0);
        chk("R1 valid", longint'(store_valid), 0);
        chk("R1 data", longint'(store_data), 0);
        chk("R1 ovf", longint'(store_ovf), 0);
        rst_n = 1'b1;
        // 0.5*0.5 then store truncated: 0x200000
        cyc(1, 2'b01, 24'h40_0000, 24'h40_0000, 0, 2'b00, 0);
        cyc(0, 2'b10, 24'h12_3456, 24'h65_4321, 1, 2'b00, 1);
        // R5 hold with garbage ops, observed via acc_out and store
        cyc(0, 2'b00, 24'h7F_FFFF, 24'h7F_FFFF, 1, 2'b11, 0);
        // -1 * -1 gives +2^47: saturates / wraps
        cyc(1, 2'b01, 24'h80_0000, 24'h80_0000, 0, 2'b00, 0);
        cyc(0, 2'b00, 0, 0, 1, 2'b00, 1);
        cyc(0, 2'b00, 0, 0, 1, 2'b01, 0);
        // exact half with even keep: 2^11 * 2^11 * 2 = 2^23
        for (int m = 0; m < 4; m++) begin
            cyc(1, 2'b01, 24'd2048, 24'd2048, 0, 2'b00, 0);
            cyc(0, 2'b00, 0, 0, 1, 2'(m), 1);
        end
        // exact half with odd keep
        for (int m = 0; m < 3; m++) begin
            cyc(1, 2'b01, 24'd6144, 24'd2048, 0, 2'b00, 0);
            cyc(0, 2'b00, 0, 0, 1, 2'(m), 1);
        end
        // negative exact half, then just above and below half
        for (int m = 0; m < 3; m++) begin
            cyc(1, 2'b01, 24'hFF_F800, 24'd2048, 0, 2'b00, 0);
            cyc(1, 2'b10, 24'd1, 24'd1, 1, 2'(m), 1);
            cyc(1, 2'b11, 24'd1, 24'd2, 1, 2'(m), 1);
        end
        // guard-bit growth beyond the product range, then negative clamp
        cyc(1, 2'b00, 0, 0, 0, 2'b00, 0);
        for (int i = 0; i < 200; i++) cyc(1, 2'b10, 24'h80_0000, 24'h80_0000, 0, 2'b00, 0);
        cyc(0, 2'b00, 0, 0, 1, 2'b10, 1);
        for (int i = 0; i < 400; i++) cyc(1, 2'b11, 24'h80_0000, 24'h80_0000, 0, 2'b00, 0);
        cyc(0, 2'b00, 0, 0, 1, 2'b01, 1);
        cyc(1, 2'b10, 24'h00_0003, 24'h7F_FFFF, 1, 2'b00, 0);
        cyc(1, 2'b00, 0, 0, 1, 2'b01, 1);
        // seeded random mix
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] rx, ry;
            rx = 24'($urandom);
            ry = 24'($urandom);
            if ($urandom % 4 == 0) rx = 24'($urandom % 4096);
            cyc(1'($urandom % 5 != 0), 2'($urandom), rx, ry,
                1'($urandom), 2'($urandom), 1'($urandom));
        end
        report();
    end
endmodule